// File: doc/BRIEF.md
# Gray-Coded Pulse Event Counter with Cross-Domain Readout

This block counts rising edges on a pulse input that serves as its own clock, with no relation to the system clock. The running count is kept as a Gray code. Because only one bit changes per event, the system domain can sample it at any moment and never sees a torn multi-bit value. A system-side capture request passes through a synchroniser first. On its rising edge the block converts the synchronised Gray count to binary, stores the result and raises a valid flag. The flag and the stored value then stay fixed until the next request.

The system domain is built around a three-state capture machine:
- `CAP_IDLE` is the state after reset, with nothing captured yet.
- `CAP_LATCH` is the cycle in which a fresh value has just been stored.
- `CAP_SHOW` holds the stored value with valid high.

Transitions:
- Any synchronised request edge moves the machine to `CAP_LATCH`, from any state.
- `CAP_LATCH` always moves to `CAP_SHOW`.
- `CAP_IDLE` and `CAP_SHOW` stay put when no request edge arrives.

One asynchronous active-low reset serves both domains. It is released through a separate two-flop synchroniser in each domain.

Top module: `gray_event_counter`

## Requirements
- R1: With the pulse input quiet, a capture returns exactly the number of pulse rising edges counted since reset release, as an unsigned binary value of COUNT_W bits.
- R2: The internal Gray count changes in exactly one bit per counted edge.
- R3: A capture taken while pulses arrive returns a count no lower than the count when the request was raised and no higher than the count when valid rose.
- R4: The request is detected on its rising edge after two system-clock synchroniser flops. Holding the request high causes no further capture, so `count_bin` stays unchanged while pulses continue.
- R5: While valid is high and no new request edge arrives, `count_bin` holds steady.
- R6: When the request is driven high just after a falling system-clock edge, valid is low after the third following rising edge and high after the fourth.
- R7: The count wraps from all ones to zero, and the Gray code still changes in one bit across the wrap.
- R8: While reset is asserted, `count_bin` is zero and valid is low. After release, the first two pulse rising edges only finish the counter-domain reset release and are not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | System clock for the capture side |
| arst_n | input | 1 | Asynchronous active-low reset for both domains |
| pulse_in | input | 1 | Event input; each rising edge is one count |
| capture_req | input | 1 | Capture request, asynchronous to sys_clk; acts on its rising edge |
| count_bin | output | COUNT_W | Captured count in binary |
| count_valid | output | 1 | High when count_bin holds a completed capture |

## Verification
A wrong Gray register shows up as a captured value that jumps by more than one, or that differs from the pulse total by a constant offset, on the very next quiet capture. A capture machine stuck in one state shows up as valid never rising, or never dropping, on the fourth system edge after a request. A faulty request edge detector shows up as `count_bin` moving while the request is held high. A bad wrap shows up within one counter period as a nonzero capture after exactly 2^COUNT_W events.

// File: rtl/gcc_pkg.sv
package gcc_pkg;
    typedef enum logic [1:0] {
        CAP_IDLE  = 2'd0,
        CAP_LATCH = 2'd1,
        CAP_SHOW  = 2'd2
    } cap_state_t;
endpackage

// File: rtl/gcc_rst_sync.sv
module gcc_rst_sync (
    input  logic clk,
    input  logic arst_n,
    output logic srst_n
);
    logic stage1;
    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            stage1 <= 1'b0;
            srst_n <= 1'b0;
        end else begin
            stage1 <= 1'b1;
            srst_n <= stage1;
        end
    end
endmodule

// File: rtl/gcc_sync.sv
module gcc_sync #(
    parameter int WIDTH = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] meta;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/gcc_gray2bin.sv
module gcc_gray2bin #(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] gray,
    output logic [WIDTH-1:0] bin
);
    // Prefix XOR from the most significant bit downward
    assign bin[WIDTH-1] = gray[WIDTH-1];
    for (genvar i = WIDTH - 2; i >= 0; i--) begin : g_px
        assign bin[i] = bin[i+1] ^ gray[i];
    end
endmodule

// File: rtl/gcc_gray_counter.sv
module gcc_gray_counter #(
    parameter int WIDTH = 16
) (
    input  logic             pulse_clk,
    input  logic             rst_n,
    output logic [WIDTH-1:0] gray_q
);
    localparam logic [WIDTH-1:0] GRAY_TOP = {1'b1, {(WIDTH-1){1'b0}}};

    logic [WIDTH-1:0] bin_now;
    logic [WIDTH-1:0] bin_next;

    gcc_gray2bin #(.WIDTH(WIDTH)) u_dec (
        .gray (gray_q),
        .bin  (bin_now)
    );

    assign bin_next = bin_now + 1'b1;

    always_ff @(posedge pulse_clk or negedge rst_n) begin
        if (!rst_n) begin
            gray_q <= '0;
        end else begin
            gray_q <= bin_next ^ (bin_next >> 1);
        end
    end

    // R2: one bit flips per counted edge
    a_r2_single_bit_step: assert property (@(posedge pulse_clk) disable iff (!rst_n)
        (gray_q != $past(gray_q)) |-> ($countones(gray_q ^ $past(gray_q)) == 1));

    // R7: the Gray code of all ones is followed by zero
    a_r7_wrap_to_zero: assert property (@(posedge pulse_clk) disable iff (!rst_n)
        ($past(gray_q) == GRAY_TOP) |-> (gray_q == '0));
endmodule

// File: rtl/gcc_capture_fsm.sv
module gcc_capture_fsm
    import gcc_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_s,
    input  logic [WIDTH-1:0] gray_s,
    output logic [WIDTH-1:0] count_bin,
    output logic             count_valid
);
    cap_state_t       state;
    cap_state_t       state_nx;
    logic             req_d;
    logic             req_rise;
    logic [WIDTH-1:0] bin_s;

    gcc_gray2bin #(.WIDTH(WIDTH)) u_dec (
        .gray (gray_s),
        .bin  (bin_s)
    );

    assign req_rise = req_s & ~req_d;

    always_comb begin
        state_nx = state;
        if (req_rise) begin
            state_nx = CAP_LATCH;
        end else begin
            unique case (state)
                CAP_IDLE:  state_nx = CAP_IDLE;
                CAP_LATCH: state_nx = CAP_SHOW;
                CAP_SHOW:  state_nx = CAP_SHOW;
                default:   state_nx = CAP_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= CAP_IDLE;
            req_d <= 1'b0;
        end else begin
            state <= state_nx;
            req_d <= req_s;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_bin <= '0;
        end else if (req_rise) begin
            count_bin <= bin_s;
        end
    end

    assign count_valid = (state == CAP_SHOW);

    // R4: a request edge always moves the machine to the latch state
    a_r4_edge_latches: assert property (@(posedge clk) disable iff (!rst_n)
        req_rise |=> (state == CAP_LATCH));

    // R6: valid drops on a new request and rises one cycle after the latch
    a_r6_valid_drops: assert property (@(posedge clk) disable iff (!rst_n)
        req_rise |=> !count_valid);
    a_r6_valid_follows_latch: assert property (@(posedge clk) disable iff (!rst_n)
        (state == CAP_LATCH) && !req_rise |=> count_valid);

    // R5: the shown value holds until the next request edge
    a_r5_hold_value: assert property (@(posedge clk) disable iff (!rst_n)
        count_valid && !req_rise |=> $stable(count_bin));
endmodule

// File: rtl/gray_event_counter.sv
module gray_event_counter #(
    parameter int COUNT_W = 16
) (
    input  logic               sys_clk,
    input  logic               arst_n,
    input  logic               pulse_in,
    input  logic               capture_req,
    output logic [COUNT_W-1:0] count_bin,
    output logic               count_valid
);
    logic               cnt_rst_n;
    logic               sys_rst_n;
    logic [COUNT_W-1:0] gray_cnt;
    logic [COUNT_W-1:0] gray_sys;
    logic               req_sys;

    gcc_rst_sync u_rst_cnt (
        .clk    (pulse_in),
        .arst_n (arst_n),
        .srst_n (cnt_rst_n)
    );

    gcc_rst_sync u_rst_sys (
        .clk    (sys_clk),
        .arst_n (arst_n),
        .srst_n (sys_rst_n)
    );

    gcc_gray_counter #(.WIDTH(COUNT_W)) u_cnt (
        .pulse_clk (pulse_in),
        .rst_n     (cnt_rst_n),
        .gray_q    (gray_cnt)
    );

    gcc_sync #(.WIDTH(COUNT_W)) u_sync_cnt (
        .clk   (sys_clk),
        .rst_n (sys_rst_n),
        .d     (gray_cnt),
        .q     (gray_sys)
    );

    gcc_sync #(.WIDTH(1)) u_sync_req (
        .clk   (sys_clk),
        .rst_n (sys_rst_n),
        .d     (capture_req),
        .q     (req_sys)
    );

    gcc_capture_fsm #(.WIDTH(COUNT_W)) u_fsm (
        .clk         (sys_clk),
        .rst_n       (sys_rst_n),
        .req_s       (req_sys),
        .gray_s      (gray_sys),
        .count_bin   (count_bin),
        .count_valid (count_valid)
    );

    // R8: outputs are cleared while the system side is in reset
    a_r8_reset_clear: assert property (@(posedge sys_clk)
        !sys_rst_n |-> (count_bin == '0) && !count_valid);
endmodule

// File: tb/test_gray_event_counter.sv
module test_gray_event_counter;
    localparam int BW = 6;
    localparam int MOD = 1 << BW;

    logic          sys_clk = 1'b0;
    logic          arst_n = 1'b0;
    logic          pulse_in = 1'b0;
    logic          capture_req = 1'b0;
    logic [BW-1:0] count_bin;
    logic          count_valid;

    int checks = 0;
    int errors = 0;
    int pulse_total = 0;

    gray_event_counter #(.COUNT_W(BW)) i_gray_event_counter (
        .sys_clk     (sys_clk),
        .arst_n      (arst_n),
        .pulse_in    (pulse_in),
        .capture_req (capture_req),
        .count_bin   (count_bin),
        .count_valid (count_valid)
    );

    always #2 sys_clk = ~sys_clk;

    function automatic int expected_now();
        int e;
        e = pulse_total - 2;
        if (e < 0) e = 0;
        return e % MOD;
    endfunction

    task automatic check(input string req, input int actual, input int expect_v);
        checks++;
        if (actual != expect_v) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, actual, expect_v);
        end
    endtask

    task automatic pulse(input realtime half);
        pulse_in = 1'b1;
        pulse_total++;
        #(half);
        pulse_in = 1'b0;
        #(half);
    endtask

    // Quiet capture: request, check timing of valid and the value
    task automatic capture(input string req);
        @(negedge sys_clk);
        capture_req = 1'b1;
        repeat (3) @(posedge sys_clk);
        #1;
        check("R6 valid low after third edge", int'(count_valid), 0);
        @(posedge sys_clk);
        #1;
        check("R6 valid high after fourth edge", int'(count_valid), 1);
        check(req, int'(count_bin), expected_now());
        @(negedge sys_clk);
        capture_req = 1'b0;
        repeat (3) @(negedge sys_clk);
    endtask

    initial begin
        #800000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int lo;
        int hi;
        int diff;
        int held;
        repeat (3) @(posedge sys_clk);
        #1;
        // R8: reset state
        check("R8 count zero in reset", int'(count_bin), 0);
        check("R8 valid low in reset", int'(count_valid), 0);
        @(negedge sys_clk);
        arst_n = 1'b1;
        repeat (4) @(negedge sys_clk);
        // R8: two absorbed edges
        pulse(5.0);
        pulse(5.0);
        repeat (3) @(negedge sys_clk);
        capture("R8 first two edges not counted");

        // R1, R7: sweep every count value across two wraps
        for (int i = 0; i < 2 * MOD + 3; i++) begin
            pulse(3.0 + 0.5 * (i % 5));
            repeat (3) @(negedge sys_clk);
            capture((pulse_total - 2) % MOD == 0 ? "R7 wrap to zero" : "R1 quiet count");
        end

        // R1: burst patterns
        for (int n = 1; n < 40; n += 7) begin
            for (int k = 0; k < n; k++) pulse(2.3);
            repeat (3) @(negedge sys_clk);
            capture("R1 burst count");
        end

        // R4: holding request high does not recapture
        @(negedge sys_clk);
        for (int k = 0; k < 5; k++) pulse(4.1);
        repeat (3) @(negedge sys_clk);
        capture_req = 1'b1;
        repeat (6) @(negedge sys_clk);
        held = int'(count_bin);
        for (int k = 0; k < 9; k++) pulse(3.3);
        repeat (8) @(negedge sys_clk);
        check("R4 held request ignored", int'(count_bin), held);
        check("R5 value held while valid", int'(count_valid), 1);
        capture_req = 1'b0;
        repeat (3) @(negedge sys_clk);
        capture("R4 new edge recaptures");

        // R3, R2: captures while pulses are running
        fork
            begin
                for (int k = 0; k < 60; k++) pulse(3.7);
            end
            begin
                for (int c = 0; c < 5; c++) begin
                    @(negedge sys_clk);
                    lo = expected_now();
                    capture_req = 1'b1;
                    repeat (4) @(posedge sys_clk);
                    #1;
                    hi = expected_now();
                    diff = ((int'(count_bin) - lo) % MOD + MOD) % MOD;
                    checks++;
                    if (diff > ((hi - lo) % MOD + MOD) % MOD) begin
                        errors++;
                        $display("FAIL R3 capture in flight: actual %0d expected %0d..%0d",
                                 count_bin, lo, hi);
                    end
                    @(negedge sys_clk);
                    capture_req = 1'b0;
                    repeat (5) @(negedge sys_clk);
                end
            end
        join
        repeat (4) @(negedge sys_clk);
        capture("R3 settled count after running capture");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule